// File: doc/BRIEF.md
# UART receiver with error-tagged FIFO

This block turns an asynchronous serial line into characters. A one-cycle enable pulse at sixteen times the bit rate drives all sampling. A falling edge on the idle-high line opens a character. The start bit is confirmed at its midpoint, and every later bit is sampled at its own midpoint. The receiver accepts 5 to 8 data bits, sent least significant bit first. A parity bit is optional, and it may be even, odd or forced to a fixed value. The character ends with one or two stop bits.

Each finished character is written into a 16-entry FIFO as a 12-bit word. Four status flags travel with the byte, so that any later error can be traced to the character it belongs to. A consumer reads the head word and pulses a pop strobe to advance. The empty and full flags report the queue's state. When the FIFO is switched off, it acts as a single holding register. An input that selects the local transmit line in place of the serial pin lets the receiver check the transmitter without any outside wiring.

Top module: `uart_rx_tagged`

## Requirements
- R1: `rd_word` holds the head entry: character in bits 7:0 (bits above the word length read 0), framing error bit 8, parity error bit 9, break bit 10, overrun bit 11; while the FIFO is empty `rd_word` is zero.
- R2: `line_ctl[6:5]` sets the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8, received LSB first.
- R3: `line_ctl[1]` enables a parity bit after the data. `line_ctl[2]`=1 expects even parity and 0 expects odd. With `line_ctl[7]` set, the bit is instead expected to be 0 when `line_ctl[2]`=1 and 1 when it is 0. A mismatch sets bit 9.
- R4: `line_ctl[3]` selects two stop bits. A stop bit sampled low sets bit 8. After that the receiver waits for the line to go high before it looks for a new start bit.
- R5: A start bit is only accepted if the line is still low 8 ticks after the falling edge is detected. A shorter low pulse produces no entry.
- R6: A line held low through the data, parity and stop positions gives a single entry of 0x500 (zero character, break and framing set).
- R7: With `line_ctl[4]`=1 the FIFO holds 16 entries in arrival order. `st_empty` is high with no entries, and `st_full` is high when the FIFO holds its capacity.
- R8: A character that arrives while the FIFO is full is discarded. The next entry written afterwards has bit 11 set.
- R9: With `line_ctl[4]`=0 the capacity is one entry, with the same overrun rule.
- R10: Any change of `line_ctl[4]` empties the FIFO and clears a pending overrun.
- R11: The receiver runs only while `mode_ctl[0]` and `mode_ctl[9]` are both 1. Otherwise the line produces no entries.
- R12: With `mode_ctl[7]`=1 the receiver samples `tx_loop` and ignores `rx_serial`.
- R13: A `rd_pop` pulse removes the head entry. A pulse while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Sampling enable, one pulse per sixteenth of a bit |
| rx_serial | input | 1 | Serial input, idle high |
| tx_loop | input | 1 | Local transmit line used in loopback |
| mode_ctl | input | 16 | Bit 0 block enable, bit 7 loopback, bit 9 receive enable |
| line_ctl | input | 8 | Frame format and FIFO enable, fields as in R2 to R4 and R7 |
| rd_pop | input | 1 | Pops the head entry |
| rd_word | output | 12 | Head entry, layout as in R1 |
| st_empty | output | 1 | FIFO holds no entries |
| st_full | output | 1 | FIFO is at capacity |

## Verification
The hardest case to reach is the overrun tag. The FIFO has to be filled without any reads, one more character has to arrive, and only a later character may carry bit 11. The stimulus sends seventeen characters, drains all sixteen stored words, checks that the dropped one never appears, and then sends one more. The same sequence is repeated with the FIFO switched off, where the capacity is one entry. Start-glitch and break cases need line lows of exact lengths (a quarter bit, and twelve bit times), so they are driven directly. Random frame formats with occasional bad parity or stop bits cover the remaining flag combinations.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;

  // Layout of one stored word, MSB first: overrun, break, parity, framing, char.
  typedef struct packed {
    logic       ovr;
    logic       brk;
    logic       par;
    logic       frm;
    logic [7:0] ch;
  } rx_word_t;

  localparam int WORD_W = $bits(rx_word_t);

  // Number of data bits for a length code.
  function automatic logic [3:0] char_len(input logic [1:0] wl);
    return 4'd5 + {2'b00, wl};
  endfunction

  // Data arrives LSB first into the top of the shifter; move it down.
  function automatic logic [7:0] align_char(input logic [7:0] sh, input logic [1:0] wl);
    return sh >> (3'd3 - {1'b0, wl});
  endfunction

  // Expected parity bit for an aligned character.
  function automatic logic parity_bit(input logic [7:0] ch, input logic even,
                                      input logic stick);
    if (stick) return ~even;
    return even ? ^ch : ~^ch;
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
`timescale 1ns/1ps
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] r;

  // Resets to the idle level of the line.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r <= '1;
    else        r <= {r[STAGES-2:0], d};
  end

  assign q = r[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
`timescale 1ns/1ps
module uart_rx_framer
  import uart_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     active,
  input  logic     tick,
  input  logic     rx_in,
  input  logic [1:0] wl,
  input  logic     par_en,
  input  logic     even,
  input  logic     stick,
  input  logic     two_stop,
  output logic     push_evt,
  output rx_word_t push_word
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD} st_t;

  st_t        state;
  logic [3:0] tcnt;
  logic [2:0] bitn;
  logic [7:0] shreg;
  logic       par_err, frm_err, all_low, stop_n;

  logic       mid, last_data, last_stop, fe_now, brk_now;
  logic [7:0] ch;

  // Start is confirmed 8 ticks after detection; all other bits 16 ticks apart.
  assign mid       = tick && ((state == S_START) ? (tcnt == 4'd7) : (tcnt == 4'd15));
  assign ch        = align_char(shreg, wl);
  assign last_data = ({1'b0, bitn} == (char_len(wl) - 4'd1));
  assign last_stop = !two_stop || stop_n;
  assign fe_now    = frm_err || !rx_in;
  assign brk_now   = all_low && !rx_in;
  assign push_evt  = active && mid && (state == S_STOP) && last_stop;

  always_comb begin
    push_word     = '0;
    push_word.frm = fe_now;
    push_word.brk = brk_now;
    push_word.par = brk_now ? 1'b0 : par_err;
    push_word.ch  = brk_now ? 8'h00 : ch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      tcnt    <= '0;
      bitn    <= '0;
      shreg   <= '0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
      all_low <= 1'b0;
      stop_n  <= 1'b0;
    end else if (!active) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE: if (tick && !rx_in) begin
          state   <= S_START;
          tcnt    <= '0;
          bitn    <= '0;
          shreg   <= '0;
          par_err <= 1'b0;
          frm_err <= 1'b0;
          all_low <= 1'b1;
          stop_n  <= 1'b0;
        end
        S_START: begin
          if (mid) begin
            tcnt  <= '0;
            state <= rx_in ? S_IDLE : S_DATA;
          end else if (tick) tcnt <= tcnt + 4'd1;
        end
        S_DATA: begin
          if (mid) begin
            tcnt    <= '0;
            shreg   <= {rx_in, shreg[7:1]};
            all_low <= all_low && !rx_in;
            if (last_data) begin
              bitn  <= '0;
              state <= par_en ? S_PAR : S_STOP;
            end else bitn <= bitn + 3'd1;
          end else if (tick) tcnt <= tcnt + 4'd1;
        end
        S_PAR: begin
          if (mid) begin
            tcnt    <= '0;
            all_low <= all_low && !rx_in;
            par_err <= (rx_in != parity_bit(ch, even, stick));
            state   <= S_STOP;
          end else if (tick) tcnt <= tcnt + 4'd1;
        end
        S_STOP: begin
          if (mid) begin
            tcnt    <= '0;
            all_low <= brk_now;
            frm_err <= fe_now;
            if (last_stop) state <= fe_now ? S_HOLD : S_IDLE;
            else           stop_n <= 1'b1;
          end else if (tick) tcnt <= tcnt + 4'd1;
        end
        S_HOLD: if (tick && rx_in) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_tagfifo.sv
`timescale 1ns/1ps
module uart_rx_tagfifo #(
  parameter int DEPTH = 16,
  parameter int W     = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         one_deep,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full,
  output logic         accepted
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count, cap;
  logic          do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cap      = one_deep ? CW'(1) : CW'(DEPTH);
  assign empty    = (count == '0);
  assign full     = (count >= cap);
  assign do_pop   = pop && !empty && !flush;
  assign accepted = push && !flush && (!full || do_pop);
  assign rdata    = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (accepted) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (accepted) wp <= bump(wp);
      if (do_pop)   rp <= bump(rp);
      case ({accepted, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_tagged.sv
`timescale 1ns/1ps
module uart_rx_tagged
  import uart_rx_pkg::*;
#(
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick16,
  input  logic        rx_serial,
  input  logic        tx_loop,
  input  logic [15:0] mode_ctl,
  input  logic [7:0]  line_ctl,
  input  logic        rd_pop,
  output logic [11:0] rd_word,
  output logic        st_empty,
  output logic        st_full
);
  logic     line_src, rx_s, rx_active;
  logic     flush, prev_fen, ovr_pend;
  logic     push_evt, accepted, drop_evt;
  rx_word_t push_word, store_word;
  logic     unused_ctl;

  assign unused_ctl = ^{mode_ctl[15:10], mode_ctl[8], mode_ctl[6:1], line_ctl[0]};

  assign line_src  = mode_ctl[7] ? tx_loop : rx_serial;
  assign rx_active = mode_ctl[0] && mode_ctl[9];

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_src), .q(rx_s)
  );

  uart_rx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .active(rx_active), .tick(tick16), .rx_in(rx_s),
    .wl(line_ctl[6:5]), .par_en(line_ctl[1]), .even(line_ctl[2]),
    .stick(line_ctl[7]), .two_stop(line_ctl[3]),
    .push_evt(push_evt), .push_word(push_word)
  );

  // FIFO-enable edge: both pointers and the pending overrun are cleared.
  assign flush = line_ctl[4] ^ prev_fen;

  always_comb begin
    store_word     = push_word;
    store_word.ovr = ovr_pend;
  end

  uart_rx_tagfifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .one_deep(!line_ctl[4]),
    .push(push_evt), .wdata(store_word), .pop(rd_pop),
    .rdata(rd_word), .empty(st_empty), .full(st_full), .accepted(accepted)
  );

  assign drop_evt = push_evt && !accepted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_fen <= 1'b0;
      ovr_pend <= 1'b0;
    end else begin
      prev_fen <= line_ctl[4];
      if (flush)         ovr_pend <= 1'b0;
      else if (drop_evt) ovr_pend <= 1'b1;
      else if (accepted) ovr_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_tagged_chk.sv
`timescale 1ns/1ps
module uart_rx_tagged_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_pop,
  input logic        st_empty,
  input logic        st_full,
  input logic [11:0] rd_word,
  input logic        push_evt,
  input logic        drop_evt,
  input logic        rx_active,
  input logic        fifo_en
);
  p_empty_reads_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st_empty |-> (rd_word == 12'h000));

  p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_empty && st_full));

  p_drop_only_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && (fifo_en == $past(fifo_en))) |-> st_full);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_full && drop_evt && (fifo_en == $past(fifo_en))) |=> st_full);

  p_quiet_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_active |=> !push_evt);

  p_pop_frees_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && !st_empty && !push_evt && (fifo_en == $past(fifo_en))) |=> !st_full);
endmodule

bind uart_rx_tagged uart_rx_tagged_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_pop(rd_pop), .st_empty(st_empty), .st_full(st_full),
  .rd_word(rd_word), .push_evt(push_evt), .drop_evt(drop_evt),
  .rx_active(rx_active), .fifo_en(line_ctl[4])
);

// File: tb/tb_uart_rx_tagged.sv
`timescale 1ns/1ps
module tb_uart_rx_tagged;
  localparam int BIT_CLKS = 64;   // 16 ticks, one tick every 4 clocks

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick16 = 1'b0;
  logic        rx_serial, tx_loop;
  logic [15:0] mode_ctl = 16'h0201;
  logic [7:0]  line_ctl = 8'h70;
  logic        rd_pop = 1'b0;
  logic [11:0] rd_word;
  logic        st_empty, st_full;

  logic       line_val = 1'b1;
  logic       use_loop = 1'b0;
  logic       stray = 1'b1;
  logic [1:0] div = 2'd0;
  int         n_checks = 0;
  int         n_fail = 0;
  int         cycles = 0;
  logic [11:0] q[$];

  assign rx_serial = use_loop ? stray : line_val;
  assign tx_loop   = use_loop ? line_val : 1'b1;

  uart_rx_tagged dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_serial(rx_serial), .tx_loop(tx_loop),
    .mode_ctl(mode_ctl), .line_ctl(line_ctl), .rd_pop(rd_pop),
    .rd_word(rd_word), .st_empty(st_empty), .st_full(st_full)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    div    = div + 2'd1;
    tick16 = (div == 2'd0);
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles == 190000) begin
      n_checks = n_checks + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_checks = n_checks + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] len_mask(input logic [7:0] lc);
    return 8'((1 << (5 + int'(lc[6:5]))) - 1);
  endfunction

  function automatic logic bench_par(input logic [7:0] d, input logic [7:0] lc);
    logic [7:0] dm;
    int ones;
    dm = d & len_mask(lc);
    ones = $countones(dm);
    if (lc[7]) return lc[2] ? 1'b0 : 1'b1;
    if (lc[2]) return (ones % 2) == 1;
    return (ones % 2) == 0;
  endfunction

  function automatic logic [11:0] exp_word(input logic [7:0] d, input logic [7:0] lc,
                                           input logic bad_par, input logic bad_stop,
                                           input logic ovr);
    return {ovr, 1'b0, bad_par & lc[1], bad_stop, d & len_mask(lc)};
  endfunction

  task automatic hold_bit(input logic b);
    line_val = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input logic bad_par, input logic bad_stop);
    int n;
    n = 5 + int'(line_ctl[6:5]);
    hold_bit(1'b0);
    for (int i = 0; i < n; i++) hold_bit(d[i]);
    if (line_ctl[1]) hold_bit(bench_par(d, line_ctl) ^ bad_par);
    hold_bit(!bad_stop);
    if (line_ctl[3]) hold_bit(1'b1);
    hold_bit(1'b1);
  endtask

  task automatic read_expect(input string tag, input logic [11:0] exp);
    @(negedge clk);
    check(tag, rd_word, exp);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic check_flags(input string tag, input logic e, input logic f);
    @(negedge clk);
    check({tag, " empty"}, {11'd0, st_empty}, {11'd0, e});
    check({tag, " full"}, {11'd0, st_full}, {11'd0, f});
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // Reset state (R1, R7)
    check_flags("R7 reset", 1'b1, 1'b0);
    check("R1 reset word", rd_word, 12'h000);

    // Word lengths (R2)
    for (int wl = 0; wl < 4; wl++) begin
      line_ctl = {1'b0, 2'(wl), 1'b1, 4'b0000};
      send_char(8'hB5, 1'b0, 1'b0);
      read_expect("R2 length", exp_word(8'hB5, line_ctl, 1'b0, 1'b0, 1'b0));
    end

    // Parity modes (R3): even, odd, stick-0, stick-1, then corrupted
    begin
      logic [7:0] pm[4];
      pm[0] = 8'h76; pm[1] = 8'h72; pm[2] = 8'hF6; pm[3] = 8'hF2;
      for (int k = 0; k < 4; k++) begin
        line_ctl = pm[k];
        send_char(8'h3C + 8'(k), 1'b0, 1'b0);
        read_expect("R3 parity ok", exp_word(8'h3C + 8'(k), line_ctl, 1'b0, 1'b0, 1'b0));
        send_char(8'h5A + 8'(k), 1'b1, 1'b0);
        read_expect("R3 parity bad", exp_word(8'h5A + 8'(k), line_ctl, 1'b1, 1'b0, 1'b0));
      end
    end

    // Stop bits and framing (R4)
    line_ctl = 8'h78;
    send_char(8'hC3, 1'b0, 1'b0);
    read_expect("R4 two stop", exp_word(8'hC3, line_ctl, 1'b0, 1'b0, 1'b0));
    send_char(8'h81, 1'b0, 1'b1);
    read_expect("R4 two stop framing", exp_word(8'h81, line_ctl, 1'b0, 1'b1, 1'b0));
    line_ctl = 8'h70;
    send_char(8'h55, 1'b0, 1'b1);
    read_expect("R4 framing", 12'h155);
    send_char(8'h2E, 1'b0, 1'b0);
    read_expect("R4 recovery", 12'h02E);

    // False start (R5)
    line_val = 1'b0;
    repeat (16) @(negedge clk);
    line_val = 1'b1;
    repeat (200) @(negedge clk);
    check_flags("R5 glitch", 1'b1, 1'b0);
    send_char(8'h9D, 1'b0, 1'b0);
    read_expect("R5 after glitch", 12'h09D);

    // Break (R6)
    line_val = 1'b0;
    repeat (12 * BIT_CLKS) @(negedge clk);
    line_val = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
    read_expect("R6 break", 12'h500);
    check_flags("R6 single entry", 1'b1, 1'b0);

    // Receiver gating (R11)
    mode_ctl = 16'h0001;
    send_char(8'h11, 1'b0, 1'b0);
    check_flags("R11 rx off", 1'b1, 1'b0);
    mode_ctl = 16'h0200;
    send_char(8'h12, 1'b0, 1'b0);
    check_flags("R11 uart off", 1'b1, 1'b0);
    mode_ctl = 16'h0201;
    send_char(8'h13, 1'b0, 1'b0);
    read_expect("R11 on again", 12'h013);

    // Loopback (R12): pin held low, loop line carries the frame
    mode_ctl = 16'h0281;
    use_loop = 1'b1;
    stray = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    send_char(8'h96, 1'b0, 1'b0);
    read_expect("R12 loopback", 12'h096);
    check_flags("R12 pin ignored", 1'b1, 1'b0);
    mode_ctl = 16'h0201;
    use_loop = 1'b0;
    stray = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);

    // Fill, overrun and tag (R7, R8)
    for (int i = 0; i < 16; i++) begin
      send_char(8'(i * 7 + 1), 1'b0, 1'b0);
      if (i == 14) check_flags("R7 fifteen", 1'b0, 1'b0);
    end
    check_flags("R7 full", 1'b0, 1'b1);
    send_char(8'hEE, 1'b0, 1'b0);
    check_flags("R8 still full", 1'b0, 1'b1);
    for (int i = 0; i < 16; i++) read_expect("R7 order", {4'h0, 8'(i * 7 + 1)});
    check_flags("R8 drained", 1'b1, 1'b0);
    send_char(8'h42, 1'b0, 1'b0);
    read_expect("R8 overrun tag", 12'h842);

    // Single-entry mode (R9, R10)
    line_ctl = 8'h60;
    check_flags("R10 flush on disable", 1'b1, 1'b0);
    send_char(8'h11, 1'b0, 1'b0);
    check_flags("R9 one deep full", 1'b0, 1'b1);
    send_char(8'h22, 1'b0, 1'b0);
    read_expect("R9 held", 12'h011);
    send_char(8'h33, 1'b0, 1'b0);
    read_expect("R9 overrun tag", 12'h833);

    // Flush on enable change (R10)
    send_char(8'h44, 1'b0, 1'b0);
    send_char(8'h45, 1'b0, 1'b0);       // dropped, overrun pending
    line_ctl = 8'h70;
    check_flags("R10 flush on enable", 1'b1, 1'b0);
    send_char(8'h46, 1'b0, 1'b0);
    send_char(8'h47, 1'b0, 1'b0);
    check_flags("R10 holding two", 1'b0, 1'b0);
    line_ctl = 8'h60;
    check_flags("R10 flush again", 1'b1, 1'b0);
    line_ctl = 8'h70;
    send_char(8'h48, 1'b0, 1'b0);
    read_expect("R10 no stale overrun", 12'h048);

    // Pop on empty (R13)
    @(negedge clk);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    send_char(8'h6B, 1'b0, 1'b0);
    send_char(8'h6C, 1'b0, 1'b0);
    read_expect("R13 first", 12'h06B);
    read_expect("R13 second", 12'h06C);
    check_flags("R13 empty", 1'b1, 1'b0);

    // Random formats (R1..R4)
    for (int r = 0; r < 5; r++) begin
      for (int f = 0; f < 5; f++) begin
        logic [7:0] d;
        logic bp, bs;
        line_ctl = {1'($urandom), 2'($urandom), 1'b1, 1'($urandom), 1'($urandom),
                    1'($urandom), 1'b0};
        d  = 8'($urandom);
        bp = line_ctl[1] && (($urandom % 4) == 0);
        bs = (($urandom % 5) == 0);
        if (bs) d[0] = 1'b1;
        send_char(d, bp, bs);
        q.push_back(exp_word(d, line_ctl, bp, bs, 1'b0));
      end
      while (q.size() > 0) read_expect("R1 random frame", q.pop_front());
    end

    finish_run();
  end
endmodule